// File: doc/BRIEF.md
# Single-Wire Pulse-Width Serial Slave

This block is the device end of a one-wire, open-drain serial link that idles high. The host signals each bit by pulling the line low at the start of a fixed-length bit window: a short low pulse means 1, a long one means 0. A low level that lasts much longer than any data pulse is a break. A break throws away any partial byte and returns the link to waiting for a command. All timing limits are parameters counted in system-clock cycles.

The first byte after a break, or after a completed transaction, is a command. Its top bit selects write (1) or read (0), and its low seven bits select a register. On a write, the next received byte goes out as a single write strobe on a plain register port. On a read, the block waits a response delay. It then samples the register read data and sends it back on the same wire, bit by bit, using the same short/long pulse encoding. Bytes travel least significant bit first in both directions. The raw line passes through a two-flop synchroniser and a glitch filter before any edge is looked at.

Top module: `sw_rtz_slave`

## Requirements
- R1: After reset, `line_drive_low` is 0 and `reg_we` is 0, and both stay 0 while the line idles high.
- R2: The width of a filtered low pulse decides the bit value. A width below SAMPLE_CYC cycles decodes as 1. A width of SAMPLE_CYC cycles or more, but below BREAK_CYC, decodes as 0. The first received bit is bit 0 of the byte.
- R3: In a command byte, bit 7 = 1 means write and bits 6..0 are the register address. The next received byte then produces exactly one cycle of `reg_we`, with `reg_addr` equal to that address and `reg_wdata` equal to that byte.
- R4: A command byte with bit 7 = 0 makes the block send `reg_rdata` of the addressed register as 8 bits, bit 0 first. Each bit occupies a TX_WIN_CYC-cycle window that begins with `line_drive_low` held for TX_ONE_CYC cycles for a 1 or TX_ZERO_CYC cycles for a 0, after which the line is released.
- R5: A low level held for BREAK_CYC cycles is a break. It discards any partially received command or data byte without a write strobe and returns the block to waiting for a command. Pulses that begin before the line has been high for RECOV_CYC cycles after the break are not decoded.
- R6: A low excursion shorter than FILT_CYC cycles at the synchroniser output is ignored and produces no bit.
- R7: The first reply pulse of a read starts no earlier than RESP_CYC cycles after the last command bit has been decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level of the shared wire, asynchronous |
| line_drive_low | output | 1 | 1 pulls the open-drain wire low |
| reg_addr | output | 7 | Register address taken from the command byte |
| reg_wdata | output | 8 | Byte to write to the register |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Read data of the register at `reg_addr` |

## Verification
On every cycle the assertions check four things. The write strobe never lasts beyond one cycle. A break is never followed by a strobe. The device never holds the wire low longer than a 0 pulse. The filtered level changes only after the synchronised input has differed from it for the full filter length. Only the bench's scenarios can show the rest. These are the correctness of decoded addresses and data, the bit order, the reply contents and pulse widths, the response gap, and the recovery of framing after a break in a command or in a data byte. The same holds for the rejection of glitch trains and for decoding pulses that sit close to the sample threshold.

// File: rtl/sw_rtz_pkg.sv
package sw_rtz_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_WDATA,
        ST_RESP,
        ST_SEND
    } ctl_st_e;

    typedef struct packed {
        logic valid;
        logic value;
    } rx_bit_t;

    typedef struct packed {
        logic       wr;
        logic [6:0] addr;
    } cmd_t;

    function automatic cnt_t sat_inc(cnt_t c);
        return (c == '1) ? c : c + 1'b1;
    endfunction

endpackage

// File: rtl/sw_rtz_front.sv
module sw_rtz_front #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic lvl,
    output logic fall,
    output logic rise
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] FLIM = FW'(FILT_CYC - 1);

    logic          s1;
    logic          s2;
    logic          lvl_d;
    logic [FW-1:0] fcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b1;
            s2    <= 1'b1;
            lvl   <= 1'b1;
            lvl_d <= 1'b1;
            fcnt  <= '0;
        end else begin
            s1    <= line_in;
            s2    <= s1;
            lvl_d <= lvl;
            if (s2 != lvl) begin
                if (fcnt == FLIM) begin
                    lvl  <= s2;
                    fcnt <= '0;
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end else begin
                fcnt <= '0;
            end
        end
    end

    assign fall = lvl_d & ~lvl;
    assign rise = ~lvl_d & lvl;

endmodule

// File: rtl/sw_rtz_rxbit.sv
module sw_rtz_rxbit
    import sw_rtz_pkg::*;
#(
    parameter int SAMPLE_CYC = 3750,
    parameter int BREAK_CYC  = 9000,
    parameter int RECOV_CYC  = 1500
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    lvl,
    input  logic    fall,
    input  logic    rise,
    output rx_bit_t bit_ev,
    output logic    brk
);
    localparam cnt_t SAMP_C = cnt_t'(SAMPLE_CYC);
    localparam cnt_t BRK_L  = cnt_t'(BREAK_CYC - 1);
    localparam cnt_t REC_L  = cnt_t'(RECOV_CYC - 1);

    logic armed;
    cnt_t low_cnt;
    cnt_t hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b1;
            low_cnt <= '0;
            hi_cnt  <= '0;
            bit_ev  <= '0;
            brk     <= 1'b0;
        end else begin
            bit_ev <= '0;
            brk    <= 1'b0;
            if (fall) begin
                low_cnt <= cnt_t'(1);
            end else if (!lvl) begin
                low_cnt <= sat_inc(low_cnt);
            end
            if (!lvl && armed && !fall && low_cnt == BRK_L) begin
                brk   <= 1'b1;
                armed <= 1'b0;
            end
            if (rise && armed) begin
                bit_ev.valid <= 1'b1;
                bit_ev.value <= (low_cnt < SAMP_C);
            end
            if (lvl && !armed) begin
                if (hi_cnt == REC_L) begin
                    armed  <= 1'b1;
                    hi_cnt <= '0;
                end else begin
                    hi_cnt <= hi_cnt + 1'b1;
                end
            end else begin
                hi_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/sw_rtz_txbit.sv
module sw_rtz_txbit
    import sw_rtz_pkg::*;
#(
    parameter int TX_ONE_CYC  = 2000,
    parameter int TX_ZERO_CYC = 6000,
    parameter int TX_WIN_CYC  = 9500
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic value,
    input  logic abort,
    output logic drive_low,
    output logic done
);
    localparam cnt_t ONE_C  = cnt_t'(TX_ONE_CYC);
    localparam cnt_t ZERO_C = cnt_t'(TX_ZERO_CYC);
    localparam cnt_t WIN_L  = cnt_t'(TX_WIN_CYC - 1);

    logic busy;
    logic val_q;
    cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            val_q <= 1'b0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy  <= 1'b1;
                cnt   <= '0;
                val_q <= value;
            end else if (busy) begin
                if (cnt == WIN_L) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign drive_low = busy && (cnt < (val_q ? ONE_C : ZERO_C));

endmodule

// File: rtl/sw_rtz_slave.sv
module sw_rtz_slave
    import sw_rtz_pkg::*;
#(
    parameter int FILT_CYC    = 8,
    parameter int SAMPLE_CYC  = 3750,
    parameter int BREAK_CYC   = 9000,
    parameter int RECOV_CYC   = 1500,
    parameter int RESP_CYC    = 9500,
    parameter int TX_ONE_CYC  = 2000,
    parameter int TX_ZERO_CYC = 6000,
    parameter int TX_WIN_CYC  = 9500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output logic       line_drive_low,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    localparam cnt_t RESP_L = cnt_t'(RESP_CYC - 1);

    logic    lvl;
    logic    fall;
    logic    rise;
    rx_bit_t bit_ev;
    logic    brk;
    logic    tx_start;
    logic    tx_done;

    ctl_st_e    st;
    logic [6:0] shreg;
    logic [7:0] tx_byte;
    logic [2:0] bitn;
    cnt_t       wait_cnt;
    logic [7:0] rx_byte;
    cmd_t       cmd;

    sw_rtz_front #(.FILT_CYC(FILT_CYC)) i_front (
        .clk(clk), .rst(rst), .line_in(line_in),
        .lvl(lvl), .fall(fall), .rise(rise)
    );

    sw_rtz_rxbit #(
        .SAMPLE_CYC(SAMPLE_CYC), .BREAK_CYC(BREAK_CYC), .RECOV_CYC(RECOV_CYC)
    ) i_rx (
        .clk(clk), .rst(rst), .lvl(lvl), .fall(fall), .rise(rise),
        .bit_ev(bit_ev), .brk(brk)
    );

    sw_rtz_txbit #(
        .TX_ONE_CYC(TX_ONE_CYC), .TX_ZERO_CYC(TX_ZERO_CYC), .TX_WIN_CYC(TX_WIN_CYC)
    ) i_tx (
        .clk(clk), .rst(rst), .start(tx_start), .value(tx_byte[0]),
        .abort(brk), .drive_low(line_drive_low), .done(tx_done)
    );

    assign rx_byte = {bit_ev.value, shreg};
    assign cmd     = cmd_t'(rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_CMD;
            shreg     <= '0;
            bitn      <= '0;
            wait_cnt  <= '0;
            tx_byte   <= '0;
            tx_start  <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
        end else begin
            reg_we   <= 1'b0;
            tx_start <= 1'b0;
            if (brk) begin
                st   <= ST_CMD;
                bitn <= '0;
            end else begin
                case (st)
                    ST_CMD: begin
                        if (bit_ev.valid) begin
                            shreg <= rx_byte[7:1];
                            bitn  <= bitn + 1'b1;
                            if (bitn == 3'd7) begin
                                reg_addr <= cmd.addr;
                                wait_cnt <= '0;
                                st       <= cmd.wr ? ST_WDATA : ST_RESP;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (bit_ev.valid) begin
                            shreg <= rx_byte[7:1];
                            bitn  <= bitn + 1'b1;
                            if (bitn == 3'd7) begin
                                reg_wdata <= rx_byte;
                                reg_we    <= 1'b1;
                                st        <= ST_CMD;
                            end
                        end
                    end
                    ST_RESP: begin
                        if (wait_cnt == RESP_L) begin
                            tx_byte  <= reg_rdata;
                            tx_start <= 1'b1;
                            bitn     <= '0;
                            st       <= ST_SEND;
                        end else begin
                            wait_cnt <= wait_cnt + 1'b1;
                        end
                    end
                    ST_SEND: begin
                        if (tx_done) begin
                            if (bitn == 3'd7) begin
                                bitn <= '0;
                                st   <= ST_CMD;
                            end else begin
                                bitn     <= bitn + 1'b1;
                                tx_byte  <= {1'b0, tx_byte[7:1]};
                                tx_start <= 1'b1;
                            end
                        end
                    end
                    default: st <= ST_CMD;
                endcase
            end
        end
    end

endmodule

// File: rtl/sw_rtz_chk.sv
module sw_rtz_chk #(
    parameter int FILT_CYC    = 8,
    parameter int TX_ZERO_CYC = 6000
) (
    input logic clk,
    input logic rst,
    input logic line_in,
    input logic lvl,
    input logic line_drive_low,
    input logic reg_we,
    input logic brk
);
    logic        m1;
    logic        m2;
    logic [15:0] drv_run;
    logic [15:0] diff_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            m1       <= 1'b1;
            m2       <= 1'b1;
            drv_run  <= '0;
            diff_run <= '0;
        end else begin
            m1       <= line_in;
            m2       <= m1;
            drv_run  <= line_drive_low ? drv_run + 1'b1 : '0;
            diff_run <= (m2 != lvl) ? diff_run + 1'b1 : '0;
        end
    end

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    a_r4_drive_bounded: assert property (@(posedge clk) disable iff (rst)
        drv_run <= 16'(TX_ZERO_CYC));

    a_r5_break_no_strobe: assert property (@(posedge clk) disable iff (rst)
        brk |=> !reg_we);

    a_r6_filter_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl) |-> $past(diff_run) >= 16'(FILT_CYC - 1));

endmodule

bind sw_rtz_slave sw_rtz_chk #(
    .FILT_CYC(FILT_CYC), .TX_ZERO_CYC(TX_ZERO_CYC)
) i_chk (
    .clk(clk), .rst(rst), .line_in(line_in), .lvl(lvl),
    .line_drive_low(line_drive_low), .reg_we(reg_we), .brk(brk)
);

// File: tb/test_sw_rtz_slave.sv
module test_sw_rtz_slave;
    localparam int FILT   = 3;
    localparam int SAMP   = 24;
    localparam int BRKC   = 70;
    localparam int RECOV  = 20;
    localparam int RESP   = 80;
    localparam int T_ONE  = 8;
    localparam int T_ZERO = 40;
    localparam int WIN    = 100;

    // {address, data}
    localparam logic [14:0] VEC [6] = '{
        {7'h00, 8'h00}, {7'h7F, 8'hFF}, {7'h3C, 8'hA5},
        {7'h12, 8'h5A}, {7'h6E, 8'h01}, {7'h41, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_low = 1'b0;
    logic       dev_low;
    wire        line;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       reg_we;
    logic [7:0] mem [128];

    int         checks = 0;
    int         errors = 0;
    int         we_cnt = 0;
    logic [6:0] last_addr = '0;
    logic [7:0] last_data = '0;
    bit         finished = 0;

    assign line      = ~(host_low | dev_low);
    assign reg_rdata = mem[reg_addr];

    always #10 clk = ~clk;

    sw_rtz_slave #(
        .FILT_CYC(FILT), .SAMPLE_CYC(SAMP), .BREAK_CYC(BRKC), .RECOV_CYC(RECOV),
        .RESP_CYC(RESP), .TX_ONE_CYC(T_ONE), .TX_ZERO_CYC(T_ZERO), .TX_WIN_CYC(WIN)
    ) i_sw_rtz_slave (
        .clk(clk), .rst(rst), .line_in(line), .line_drive_low(dev_low),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    always @(negedge clk) begin
        if (!rst && reg_we) begin
            we_cnt++;
            last_addr = reg_addr;
            last_data = reg_wdata;
            mem[reg_addr] = reg_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit_w(input int low_w);
        @(negedge clk) host_low = 1'b1;
        repeat (low_w) @(negedge clk);
        host_low = 1'b0;
        repeat (WIN - low_w) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        send_bit_w(b ? T_ONE : T_ZERO);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_break();
        @(negedge clk) host_low = 1'b1;
        repeat (BRKC + 10) @(negedge clk);
        host_low = 1'b0;
        repeat (RECOV + 20) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        send_byte({1'b1, a});
        send_byte(d);
    endtask

    task automatic do_read(input logic [6:0] a, output logic [7:0] v, output int gap);
        send_byte({1'b0, a});
        v = '0;
        gap = 0;
        for (int i = 0; i < 8; i++) begin
            int t = 0;
            int w = 0;
            while (line && t < 400) begin @(negedge clk); t++; end
            if (i == 0) gap = t;
            while (!line && w < 200) begin @(negedge clk); w++; end
            v[i] = (w < SAMP);
            check(v[i] ? (w >= T_ONE - 2 && w <= T_ONE + 2)
                       : (w >= T_ZERO - 2 && w <= T_ZERO + 2),
                  "R4 reply pulse width", w, v[i] ? T_ONE : T_ZERO);
        end
        repeat (WIN) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rv;
        int gap;
        int base;
        bit drv_seen;
        for (int i = 0; i < 128; i++) mem[i] = 8'(i ^ 8'h33);

        repeat (5) @(negedge clk);
        check(dev_low == 1'b0, "R1 drive in reset", dev_low, 0);
        check(reg_we == 1'b0, "R1 strobe in reset", reg_we, 0);
        rst = 1'b0;
        drv_seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (dev_low || reg_we) drv_seen = 1;
        end
        check(!drv_seen && we_cnt == 0, "R1 idle quiet", drv_seen, 0);

        // table of write/read-back vectors
        for (int k = 0; k < 6; k++) begin
            logic [6:0] a;
            logic [7:0] d;
            {a, d} = VEC[k];
            base = we_cnt;
            do_write(a, d);
            check(we_cnt == base + 1, "R3 one strobe", we_cnt - base, 1);
            check(last_addr == a, "R3 write address", last_addr, a);
            check(last_data == d, "R2 R3 write data", last_data, d);
            do_read(a, rv, gap);
            check(rv == d, "R4 read data", rv, d);
            check(gap + (WIN - T_ZERO) >= RESP && gap + (WIN - T_ZERO) <= RESP + 20,
                  "R7 response delay", gap + (WIN - T_ZERO), RESP);
        end

        // R2: widths close to the sample threshold
        base = we_cnt;
        send_byte({1'b1, 7'h05});
        for (int i = 0; i < 8; i++) send_bit_w((8'h96 >> i) & 1 ? SAMP - 4 : SAMP + 4);
        check(we_cnt == base + 1 && last_data == 8'h96, "R2 threshold decode", last_data, 8'h96);

        // R5: break inside a command byte, then a clean write
        base = we_cnt;
        for (int i = 0; i < 4; i++) send_bit(i[0]);
        send_break();
        do_write(7'h10, 8'h77);
        check(we_cnt == base + 1, "R5 resync after command break", we_cnt - base, 1);
        check(last_addr == 7'h10 && last_data == 8'h77, "R5 write after break", last_data, 8'h77);

        // R5: break inside a data byte drops the write
        base = we_cnt;
        send_byte({1'b1, 7'h20});
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        send_break();
        check(we_cnt == base, "R5 no strobe on data break", we_cnt - base, 0);
        do_read(7'h20, rv, gap);
        check(rv == 8'(8'h20 ^ 8'h33), "R5 register untouched", rv, 8'(8'h20 ^ 8'h33));

        // R6: short glitches are ignored
        base = we_cnt;
        for (int g = 0; g < 6; g++) begin
            @(negedge clk) host_low = 1'b1;
            repeat (FILT - 1) @(negedge clk);
            host_low = 1'b0;
            repeat (12) @(negedge clk);
        end
        check(we_cnt == base, "R6 glitches make no strobe", we_cnt - base, 0);
        do_write(7'h55, 8'h3A);
        check(we_cnt == base + 1 && last_addr == 7'h55 && last_data == 8'h3A,
              "R6 framing kept after glitches", last_data, 8'h3A);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule